// File: doc/BRIEF.md
# Two-Level Interrupt Control Register

This block is an eight-bit interrupt control register. Software reads and writes it, and hardware sets its flag bits. It holds five enable bits and three sticky event flags. The flags record a timer overflow pulse, a rising edge on an external interrupt pin, and a change on a four-bit slice of an input port. From these bits, from a peripheral request input and from per-source priority inputs, the block drives a high-priority and a low-priority interrupt request.

A mode input chooses how the two top enable bits are read. With the mode low there is a single interrupt level: bit 7 is the master gate, bit 6 also gates the peripheral request, and every request goes out on the high-priority output. With the mode high, bit 7 gates the high-priority level and bits 7 and 6 together gate the low-priority level.

The port-change detector compares the port against a snapshot of it. A port read strobe refreshes the snapshot, but only one cycle after the read. Until then the flag keeps setting itself again, even if software has cleared it.

Top module: `irq_ctrl_reg`

## Requirements
- R1: After reset the register reads 8'h00 and both request outputs are low.
- R2: A write loads all eight bits on the next clock edge. Bit 7 is the master/high-level enable, bit 6 the peripheral/low-level enable, and bits 5, 4 and 3 enable the timer, external-pin and port-change sources. Bits 2, 1 and 0 are the timer, external-pin and port-change flags.
- R3: A flag is set by its event whatever the state of its own enable bit and of bits 7 and 6.
- R4: A set flag stays set until a write puts 0 in that bit.
- R5: If a write clears a flag in the same cycle that its event occurs, the flag ends up set.
- R6: A timer overflow pulse that is high at a clock edge sets bit 2 on that edge.
- R7: The external pin passes through a two-flop synchronizer. A rising edge on the pin sets bit 1 on the third clock edge after it. A falling edge or a steady level sets nothing.
- R8: When the four port inputs differ from the snapshot at a clock edge, bit 0 is set on that edge. The snapshot resets to 4'h0.
- R9: The port read strobe is registered. The snapshot loads the port one edge after the strobe is sampled, so bit 0 keeps setting itself through that edge, and a clear written after that edge holds.
- R10: With the mode low, the high-level output is bit 7 AND (any source whose enable and flag are both set, OR the peripheral request with bit 6). The low-level output stays 0.
- R11: With the mode high, the high-level output is bit 7 AND (any enabled and flagged source whose priority input is 1, OR the peripheral request when its priority input is 1).
- R12: With the mode high, the low-level output is bit 7 AND bit 6 AND (any enabled and flagged source whose priority input is 0, OR the peripheral request when its priority input is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register contents |
| prio_mode_i | input | 1 | 1 selects two-level priority mode |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| port_i | input | PORT_W | Watched port bits |
| port_rd_i | input | 1 | Port read strobe |
| periph_req_i | input | 1 | Combined, already-enabled peripheral request |
| periph_hi_i | input | 1 | Priority of the peripheral request (1 = high) |
| src_hi_i | input | 3 | Priority per source: [2] timer, [1] external pin, [0] port change |
| irq_hi_o | output | 1 | High-priority (or single-level) interrupt request |
| irq_lo_o | output | 1 | Low-priority interrupt request |

## Verification
The hardest case to reach is the window between a port read and the snapshot refresh. Software writes a clear to the port-change flag in each of the cycles that follow a port change and a read. The clear must fail on the edge that samples the strobe and on the edge after it, and it must hold only from the edge after that. The bench drives that sequence directly. It does the same for a flag clear that coincides with a timer pulse. Random cycles then mix writes, strobes, pin toggles, port changes and mode flips, and a cycle-level model of the requirements follows them.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned SRC_TMR = 2;
  localparam int unsigned SRC_EXT = 1;
  localparam int unsigned SRC_PCH = 0;

  // packed order matches the register: gie=7, peie=6, en=5:3, fl=2:0
  typedef struct packed {
    logic               gie;
    logic               peie;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] fl;
  } ctrl_t;

  localparam int unsigned REG_W = $bits(ctrl_t);
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_i,
  input  logic              rd_i,
  output logic              mismatch_o
);
  logic [PORT_W-1:0] snap_q;
  logic              rd_q;

  // refresh lags the read by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (rd_q) snap_q <= port_i;
    end
  end

  assign mismatch_o = |(port_i ^ snap_q);
endmodule

// File: rtl/irq_ctrl_bits.sv
module irq_ctrl_bits
  import irq_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [NUM_SRC-1:0] set_i,
  output ctrl_t              ctrl_o
);
  ctrl_t wr_v, ctrl_d, ctrl_q;

  always_comb begin
    wr_v   = ctrl_t'(wr_data_i);
    ctrl_d = wr_en_i ? wr_v : ctrl_q;
    ctrl_d.fl = ctrl_d.fl | set_i;  // hardware set wins over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
  import irq_ctrl_pkg::*;
(
  input  ctrl_t              ctrl_i,
  input  logic               prio_mode_i,
  input  logic [NUM_SRC-1:0] src_hi_i,
  input  logic               periph_req_i,
  input  logic               periph_hi_i,
  output logic               irq_hi_o,
  output logic               irq_lo_o
);
  logic [NUM_SRC-1:0] act, hi_src, lo_src;
  logic               per_hi, per_lo;

  assign act = ctrl_i.en & ctrl_i.fl;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hi_src[i] = act[i] & (~prio_mode_i | src_hi_i[i]);
    assign lo_src[i] = act[i] & prio_mode_i & ~src_hi_i[i];
  end

  assign per_hi = periph_req_i & (prio_mode_i ? periph_hi_i : ctrl_i.peie);
  assign per_lo = periph_req_i & prio_mode_i & ~periph_hi_i;

  assign irq_hi_o = ctrl_i.gie & ((|hi_src) | per_hi);
  assign irq_lo_o = ctrl_i.gie & ctrl_i.peie & ((|lo_src) | per_lo);
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned PORT_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_data_i,
  output logic [7:0]         rd_data_o,
  input  logic               prio_mode_i,
  input  logic               tmr_ovf_i,
  input  logic               ext_pin_i,
  input  logic [PORT_W-1:0]  port_i,
  input  logic               port_rd_i,
  input  logic               periph_req_i,
  input  logic               periph_hi_i,
  input  logic [2:0]         src_hi_i,
  output logic               irq_hi_o,
  output logic               irq_lo_o
);
  logic               ext_rise, port_mis;
  logic [NUM_SRC-1:0] set_v;
  ctrl_t              ctrl;

  irq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_o (ext_rise)
  );

  irq_port_watch #(.PORT_W(PORT_W)) u_port_watch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .port_i     (port_i),
    .rd_i       (port_rd_i),
    .mismatch_o (port_mis)
  );

  always_comb begin
    set_v          = '0;
    set_v[SRC_TMR] = tmr_ovf_i;
    set_v[SRC_EXT] = ext_rise;
    set_v[SRC_PCH] = port_mis;
  end

  irq_ctrl_bits u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .set_i     (set_v),
    .ctrl_o    (ctrl)
  );

  irq_req_gate u_gate (
    .ctrl_i       (ctrl),
    .prio_mode_i  (prio_mode_i),
    .src_hi_i     (src_hi_i),
    .periph_req_i (periph_req_i),
    .periph_hi_i  (periph_hi_i),
    .irq_hi_o     (irq_hi_o),
    .irq_lo_o     (irq_lo_o)
  );

  assign rd_data_o = ctrl;
endmodule

// File: rtl/irq_ctrl_reg_chk.sv
module irq_ctrl_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       prio_mode_i,
  input logic       tmr_ovf_i,
  input logic       irq_hi_o,
  input logic       irq_lo_o
);
  p_enables_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[7:3] == $past(wr_data_i[7:3]));

  p_tmr_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[2] && !wr_en_i |=> rd_data_o[2]);

  p_tmr_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i && wr_en_i && !wr_data_i[2] |=> rd_data_o[2]);

  p_tmr_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> rd_data_o[2]);

  p_single_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prio_mode_i |-> !irq_lo_o);

  p_master_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[7] |-> !irq_hi_o && !irq_lo_o);

  p_low_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[6] |-> !irq_lo_o);
endmodule

bind irq_ctrl_reg irq_ctrl_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .prio_mode_i (prio_mode_i),
  .tmr_ovf_i   (tmr_ovf_i),
  .irq_hi_o    (irq_hi_o),
  .irq_lo_o    (irq_lo_o)
);

// File: tb/irq_ctrl_reg_bench.sv
`timescale 1ns/1ps
module irq_ctrl_reg_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       prio_mode = 1'b0;
  logic       tmr_ovf = 1'b0;
  logic       ext_pin = 1'b0;
  logic [3:0] port = '0;
  logic       port_rd = 1'b0;
  logic       periph_req = 1'b0;
  logic       periph_hi = 1'b0;
  logic [2:0] src_hi = '0;
  logic       irq_hi, irq_lo;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // model state, built from the requirements
  logic [7:0] m_reg = '0;
  logic [3:0] m_snap = '0;
  logic       m_rdq = 1'b0;
  logic [2:0] m_sh = '0;
  logic [7:0] n_reg;
  logic [3:0] n_snap;
  logic       n_rdq;
  logic [2:0] n_sh;

  always #10 clk = ~clk;

  irq_ctrl_reg u_irq_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .prio_mode_i(prio_mode), .tmr_ovf_i(tmr_ovf),
    .ext_pin_i(ext_pin), .port_i(port), .port_rd_i(port_rd),
    .periph_req_i(periph_req), .periph_hi_i(periph_hi), .src_hi_i(src_hi),
    .irq_hi_o(irq_hi), .irq_lo_o(irq_lo)
  );

  function automatic logic [1:0] exp_irq(logic [7:0] r, logic pm, logic [2:0] sh,
                                         logic pr, logic ph);
    logic [2:0] act;
    logic hi, lo;
    act = r[5:3] & r[2:0];
    if (!pm) begin
      hi = r[7] & ((|act) | (pr & r[6]));
      lo = 1'b0;
    end else begin
      hi = r[7] & ((|(act & sh)) | (pr & ph));
      lo = r[7] & r[6] & ((|(act & ~sh)) | (pr & ~ph));
    end
    return {hi, lo};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // advance one clock; model follows; compare at negedge
  task automatic cycle();
    logic [1:0] ei;
    n_reg = wr_en ? wr_data : m_reg;
    n_reg[2] = n_reg[2] | tmr_ovf;
    n_reg[1] = n_reg[1] | (m_sh[1] & ~m_sh[2]);
    n_reg[0] = n_reg[0] | (port != m_snap);
    n_sh   = {m_sh[1:0], ext_pin};
    n_rdq  = port_rd;
    n_snap = m_rdq ? port : m_snap;
    @(negedge clk);
    cyc++;
    m_reg = n_reg; m_sh = n_sh; m_rdq = n_rdq; m_snap = n_snap;
    chk("R4 register model", rd_data, m_reg);
    ei = exp_irq(m_reg, prio_mode, src_hi, periph_req, periph_hi);
    chk(prio_mode ? "R11 R12 requests" : "R10 requests", {6'b0, irq_hi, irq_lo}, {6'b0, ei});
  endtask

  task automatic write(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
  endtask

  task automatic idle();
    wr_en = 1'b0; tmr_ovf = 1'b0; port_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset value", rd_data, 8'h00);
    chk("R1 reset requests", {6'b0, irq_hi, irq_lo}, 8'h00);

    write(8'hF8); cycle(); idle();
    chk("R2 enables load", rd_data, 8'hF8);
    write(8'h00); cycle(); idle();

    // flag set with every enable off
    tmr_ovf = 1'b1; cycle(); idle();
    chk("R3 R6 timer flag", rd_data, 8'h04);
    chk("R3 no request", {7'b0, irq_hi}, 8'h00);
    cycle();
    chk("R4 sticky", rd_data, 8'h04);
    write(8'h00); cycle(); idle();
    chk("R4 clear by write", rd_data, 8'h00);
    write(8'h00); tmr_ovf = 1'b1; cycle(); idle();
    chk("R5 set beats clear", rd_data, 8'h04);
    write(8'h00); cycle(); idle();

    ext_pin = 1'b1;
    cycle(); chk("R7 edge 1", rd_data, 8'h00);
    cycle(); chk("R7 edge 2", rd_data, 8'h00);
    cycle(); chk("R7 edge 3", rd_data, 8'h02);
    write(8'h00); cycle(); idle();
    ext_pin = 1'b0;
    repeat (4) cycle();
    chk("R7 fall ignored", rd_data, 8'h00);

    port = 4'hA; cycle();
    chk("R8 mismatch sets", rd_data, 8'h01);
    write(8'h00); cycle(); idle();
    chk("R9 clear lost while mismatched", rd_data, 8'h01);
    write(8'h00); port_rd = 1'b1; cycle(); idle();
    chk("R9 clear lost at read edge", rd_data, 8'h01);
    write(8'h00); cycle(); idle();
    chk("R9 clear lost at refresh edge", rd_data, 8'h01);
    write(8'h00); cycle(); idle();
    chk("R9 clear holds after refresh", rd_data, 8'h00);

    write(8'b1010_0100); cycle(); idle();
    chk("R10 single level", {6'b0, irq_hi, irq_lo}, 8'h02);
    prio_mode = 1'b1; src_hi = 3'b000; cycle();
    chk("R11 low source off high", {6'b0, irq_hi, irq_lo}, 8'h00);
    write(8'b1110_0100); cycle(); idle();
    chk("R12 low level", {6'b0, irq_hi, irq_lo}, 8'h01);
    src_hi = 3'b100; cycle();
    chk("R11 high level", {6'b0, irq_hi, irq_lo}, 8'h02);

    for (int i = 0; i < 4000; i++) begin
      wr_en      = ($urandom_range(7) == 0);
      wr_data    = 8'($urandom);
      tmr_ovf    = ($urandom_range(5) == 0);
      port_rd    = ($urandom_range(5) == 0);
      if ($urandom_range(4) == 0) ext_pin = ~ext_pin;
      if ($urandom_range(9) == 0) port = 4'($urandom);
      if ($urandom_range(49) == 0) prio_mode = ~prio_mode;
      src_hi     = 3'($urandom);
      periph_req = ($urandom_range(3) == 0);
      periph_hi  = 1'($urandom);
      cycle();
    end
    finish_run();
  end
endmodule